// File: doc/BRIEF.md
# Clock-Aware Reset Sequencer

This block controls the reset of a small microcontroller. It takes four reset sources: power-on, an external reset pin, a software request and a watchdog timeout. For each source it looks at the clock and standby state current at that moment, and from the two it decides how long to hold the internal reset. There are three possible holds:

- a full main-oscillator settling wait of 2^STAB_LOG2 clocks;
- a short pulse of INSTR_CYCLES instruction cycles, each CLKS_PER_INSTR clocks long;
- a hold that lasts for as long as the external pin stays low.

Whenever the internal reset is active, the block asks the clock logic to return to main-clock operation. When enabled, it also drives an active-low reset pin during settling waits and short pulses. A cause register records which source started the most recent sequence.

The oscillator, the clock switch and the CPU start-up are outside this block. They appear only as the operating-state input and the force-main output.

Top module: `clkrst_seq`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is 1 and `cause_o` is 0 (power-on). After `por_i` falls with `cfg_no_por_i`=0, the reset stays in the power-on state for one more clock. It then stays for a 2^STAB_LOG2-clock settling wait before release.
- R2: With `cfg_no_por_i`=1, the reset is released on the first clock after `por_i` falls, provided the external pin is high. An external reset in a non-main state then gets no settling wait; it holds only while the pin is low.
- R3: A software or watchdog request while `opstate_i`=0 (main clock) holds `sys_rst_o` for exactly CLKS_PER_INSTR*INSTR_CYCLES clocks.
- R4: A software or watchdog request while `opstate_i` is 1 (subclock), 2 (stop) or 3 (oscillator settling) holds `sys_rst_o` for exactly 2^STAB_LOG2 clocks.
- R5: An external reset in main-clock state holds `sys_rst_o` exactly as long as the pin stays low, shifted by the two-clock synchronizer.
- R6: An external reset in a non-main state holds for the settling wait. If the pin is still low after the wait, the hold continues until the pin rises.
- R7: `sys_rst_o` is never released while the synchronized external pin is low.
- R8: `rst_pin_n_o` is low only when `cfg_pin_drv_en_i`=1 and the block is in power-on, a settling wait or a short pulse. It stays high during a pin-only hold.
- R9: `force_main_o` is 1 in every cycle in which `sys_rst_o` is 1.
- R10: `cause_o` takes the value 0 for power-on, 1 for the external pin, 2 for software and 3 for watchdog. It changes only when a new sequence starts.
- R11: When requests arrive together, the longest hold wins: a settling wait beats a pin hold, and a pin hold beats a short pulse. Within one kind, the pin beats the watchdog and the watchdog beats software.
- R12: A new request during an active sequence restarts the hold from zero. While a settling wait is running, any request is treated as a non-main-state request and restarts the full wait.
- R13: A falling edge on `ext_rst_n_i` applied between edges k-1 and k first affects `sys_rst_o` at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| soft_rst_i | input | 1 | Software reset request, one clock per request |
| wdog_rst_i | input | 1 | Watchdog reset request, one clock per request |
| opstate_i | input | 2 | 0 main, 1 subclock, 2 stop, 3 oscillator settling |
| cfg_no_por_i | input | 1 | Suppress the settling wait for power-on and external resets |
| cfg_pin_drv_en_i | input | 1 | Enable driving of the reset output pin |
| sys_rst_o | output | 1 | Internal reset, active high |
| rst_pin_n_o | output | 1 | Reset output pin, active low |
| force_main_o | output | 1 | Request to the clock logic to select main-clock mode |
| cause_o | output | 2 | Source of the latest reset sequence |

## Verification
The bench targets the following corner cases, each of which a faulty design would get wrong in a visible way:

- A request that lands during a settling wait while the state input already reads main clock. A design that trusts only the input would cut the restart to a short pulse.
- A pin edge that coincides with a software request. Letting the short pulse win would release the reset too early.
- A pin held low beyond the settling wait. A design that releases at the end of the wait would drop reset with the pin still low.
- The two option inputs, checked where they change pulse lengths and pin activity. Examples are a power-on with the suppress option set, and a pin-only hold that must leave the output pin high.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_PWRON,
        ST_OSC_WAIT,
        ST_SHORT,
        ST_PIN_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_PWR  = 2'd0,
        CAUSE_PIN  = 2'd1,
        CAUSE_SOFT = 2'd2,
        CAUSE_WDOG = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        OP_MAIN       = 2'd0,
        OP_SUB        = 2'd1,
        OP_STOP       = 2'd2,
        OP_OSC_SETTLE = 2'd3
    } opstate_e;

    // ordered by length of hold: a larger value wins arbitration
    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_SHORT = 2'd1,
        CL_HOLD  = 2'd2,
        CL_STAB  = 2'd3
    } req_class_e;

endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or posedge clr_i) begin
                if (clr_i) ff_q <= '1;
                else       ff_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or posedge clr_i) begin
                if (clr_i) ff_q <= '1;
                else       ff_q <= {ff_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rstseq_arbiter.sv
`timescale 1ns/1ps
module rstseq_arbiter
    import rstseq_pkg::*;
(
    input  logic       pin_fall_i,
    input  logic       wdog_i,
    input  logic       soft_i,
    input  logic       main_ok_i,
    input  logic       no_por_i,
    output req_class_e cls_o,
    output cause_e     cause_o
);
    localparam int NSRC = 3;   // index order is tie priority: pin, watchdog, software

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] may_stab;
    req_class_e      src_cls [NSRC];

    assign req      = {soft_i, wdog_i, pin_fall_i};
    assign may_stab = {1'b1, 1'b1, !no_por_i};

    function automatic cause_e src_cause(input int idx);
        case (idx)
            0:       return CAUSE_PIN;
            1:       return CAUSE_WDOG;
            default: return CAUSE_SOFT;
        endcase
    endfunction

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            localparam req_class_e FAST = (i == 0) ? CL_HOLD : CL_SHORT;
            assign src_cls[i] = !req[i]                      ? CL_NONE :
                                (!main_ok_i && may_stab[i]) ? CL_STAB : FAST;
        end
    endgenerate

    always_comb begin
        cls_o   = CL_NONE;
        cause_o = CAUSE_PWR;
        for (int i = 0; i < NSRC; i++) begin
            if (src_cls[i] > cls_o) begin
                cls_o   = src_cls[i];
                cause_o = src_cause(i);
            end
        end
    end
endmodule

// File: rtl/rstseq_timer.sv
`timescale 1ns/1ps
module rstseq_timer #(
    parameter int STAB_LEN  = 4096,
    parameter int SHORT_LEN = 16
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic clr_i,
    input  logic run_i,
    input  logic sel_stab_i,
    output logic done_o
);
    localparam int MAXLEN = (STAB_LEN > SHORT_LEN) ? STAB_LEN : SHORT_LEN;
    localparam int CW     = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;
    localparam logic [CW-1:0] STAB_LAST  = CW'(STAB_LEN - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)      cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == (sel_stab_i ? STAB_LAST : SHORT_LAST));
endmodule

// File: rtl/clkrst_seq.sv
`timescale 1ns/1ps
module clkrst_seq
    import rstseq_pkg::*;
#(
    parameter int STAB_LOG2      = 12,
    parameter int CLKS_PER_INSTR = 4,
    parameter int INSTR_CYCLES   = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       ext_rst_n_i,
    input  logic       soft_rst_i,
    input  logic       wdog_rst_i,
    input  logic [1:0] opstate_i,
    input  logic       cfg_no_por_i,
    input  logic       cfg_pin_drv_en_i,
    output logic       sys_rst_o,
    output logic       rst_pin_n_o,
    output logic       force_main_o,
    output logic [1:0] cause_o
);
    localparam int STAB_LEN  = 1 << STAB_LOG2;
    localparam int SHORT_LEN = CLKS_PER_INSTR * INSTR_CYCLES;

    seq_state_e state_q, state_d;
    cause_e     cause_q, cause_d;
    req_class_e arb_cls;
    cause_e     arb_cause;
    logic       ext_sync_n, ext_prev_q, pin_fall;
    logic       main_ok, tmr_clr, tmr_run, tmr_sel_stab, tmr_done;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .clr_i (por_i),
        .d_i   (ext_rst_n_i),
        .q_o   (ext_sync_n)
    );

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) ext_prev_q <= 1'b1;
        else       ext_prev_q <= ext_sync_n;
    end
    assign pin_fall = ext_prev_q && !ext_sync_n;

    // during a settling wait the oscillator is by definition not ready
    assign main_ok = (state_q != ST_OSC_WAIT) && (opstate_e'(opstate_i) == OP_MAIN);

    rstseq_arbiter u_arb (
        .pin_fall_i (pin_fall),
        .wdog_i     (wdog_rst_i),
        .soft_i     (soft_rst_i),
        .main_ok_i  (main_ok),
        .no_por_i   (cfg_no_por_i),
        .cls_o      (arb_cls),
        .cause_o    (arb_cause)
    );

    assign tmr_run      = (state_q == ST_OSC_WAIT) || (state_q == ST_SHORT);
    assign tmr_sel_stab = (state_q == ST_OSC_WAIT);

    rstseq_timer #(.STAB_LEN(STAB_LEN), .SHORT_LEN(SHORT_LEN)) u_tmr (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .clr_i      (tmr_clr),
        .run_i      (tmr_run),
        .sel_stab_i (tmr_sel_stab),
        .done_o     (tmr_done)
    );

    // state register
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            state_q <= ST_PWRON;
            cause_q <= CAUSE_PWR;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        tmr_clr = 1'b0;
        if (arb_cls != CL_NONE) begin
            cause_d = arb_cause;
            tmr_clr = 1'b1;
            unique case (arb_cls)
                CL_STAB: state_d = ST_OSC_WAIT;
                CL_HOLD: state_d = ST_PIN_HOLD;
                default: state_d = ST_SHORT;
            endcase
        end else begin
            unique case (state_q)
                ST_RUN:      state_d = ST_RUN;
                ST_PWRON: begin
                    tmr_clr = 1'b1;
                    if (!cfg_no_por_i) state_d = ST_OSC_WAIT;
                    else               state_d = ext_sync_n ? ST_RUN : ST_PIN_HOLD;
                end
                ST_OSC_WAIT,
                ST_SHORT: begin
                    if (tmr_done) state_d = ext_sync_n ? ST_RUN : ST_PIN_HOLD;
                end
                ST_PIN_HOLD: begin
                    if (ext_sync_n) state_d = ST_RUN;
                end
                default:     state_d = ST_PWRON;
            endcase
        end
    end

    // outputs
    always_comb begin
        sys_rst_o    = 1'b1;
        rst_pin_n_o  = 1'b1;
        force_main_o = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                sys_rst_o    = 1'b0;
                force_main_o = 1'b0;
            end
            ST_PWRON, ST_OSC_WAIT, ST_SHORT: rst_pin_n_o = !cfg_pin_drv_en_i;
            ST_PIN_HOLD:                     rst_pin_n_o = 1'b1;
            default:                         rst_pin_n_o = !cfg_pin_drv_en_i;
        endcase
        cause_o = cause_q;
    end
endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk (
    input logic       clk_i,
    input logic       por_i,
    input logic       ext_sync_n_i,
    input logic       cfg_pin_drv_en_i,
    input logic       sys_rst_i,
    input logic       rst_pin_n_i,
    input logic       force_main_i,
    input logic [1:0] cause_i
);
    a_r1_por_holds: assert property (@(posedge clk_i)
        por_i |-> (sys_rst_i && cause_i == 2'd0));

    a_r7_no_release_pin_low: assert property (@(posedge clk_i) disable iff (por_i)
        (sys_rst_i && !ext_sync_n_i) |=> sys_rst_i);

    a_r8_pin_needs_enable: assert property (@(posedge clk_i) disable iff (por_i)
        !cfg_pin_drv_en_i |-> rst_pin_n_i);

    a_r8_pin_within_reset: assert property (@(posedge clk_i) disable iff (por_i)
        !rst_pin_n_i |-> sys_rst_i);

    a_r9_force_main: assert property (@(posedge clk_i) disable iff (por_i)
        sys_rst_i |-> force_main_i);

    a_r10_cause_stable_in_run: assert property (@(posedge clk_i) disable iff (por_i)
        !sys_rst_i |-> $stable(cause_i));
endmodule

bind clkrst_seq rstseq_chk u_chk (
    .clk_i            (clk_i),
    .por_i            (por_i),
    .ext_sync_n_i     (ext_sync_n),
    .cfg_pin_drv_en_i (cfg_pin_drv_en_i),
    .sys_rst_i        (sys_rst_o),
    .rst_pin_n_i      (rst_pin_n_o),
    .force_main_i     (force_main_o),
    .cause_i          (cause_o)
);

// File: tb/clkrst_seq_tb_top.sv
`timescale 1ns/1ps
module clkrst_seq_tb_top;
    localparam int CLK_P     = 10;
    localparam int STAB_LOG2 = 5;
    localparam int CPI       = 4;
    localparam int NINSTR    = 4;
    localparam int STAB_LEN  = 1 << STAB_LOG2;
    localparam int SHORT_LEN = CPI * NINSTR;

    logic clk = 1'b0;
    logic por = 1'b0;
    logic ext_n = 1'b1, sw = 1'b0, wdt = 1'b0;
    logic [1:0] op = 2'd0;
    logic no_por = 1'b0, pin_en = 1'b1;
    logic sys_rst, pin_n, force_main;
    logic [1:0] cause;

    int vectors = 0, fails = 0;
    bit done = 0;
    string cur_req = "R1";
    int meas_n;
    bit pin_low_seen, force_bad;

    always #(CLK_P/2) clk = ~clk;

    clkrst_seq #(.STAB_LOG2(STAB_LOG2), .CLKS_PER_INSTR(CPI), .INSTR_CYCLES(NINSTR)) dut_i (
        .clk_i(clk), .por_i(por), .ext_rst_n_i(ext_n), .soft_rst_i(sw), .wdog_rst_i(wdt),
        .opstate_i(op), .cfg_no_por_i(no_por), .cfg_pin_drv_en_i(pin_en),
        .sys_rst_o(sys_rst), .rst_pin_n_o(pin_n), .force_main_o(force_main), .cause_o(cause)
    );

    // reference model: kind 0 run, 1 power-on, 2 settling, 3 short, 4 pin hold
    int mk = 1, mcnt = 0, mcause = 0;
    bit ms1 = 1, ms2 = 1, mprev = 1;

    always @(posedge clk or posedge por) begin
        if (por) begin
            mk = 1; mcnt = 0; mcause = 0; ms1 = 1; ms2 = 1; mprev = 1;
        end else begin
            bit fall, low, mainok;
            int best, bc, t;
            fall = mprev && !ms2;
            low = !ms2;
            mainok = (mk != 2) && (op == 2'd0);
            best = 0; bc = 0;
            if (fall) begin t = (!mainok && !no_por) ? 3 : 2; if (t > best) begin best = t; bc = 1; end end
            if (wdt)  begin t = mainok ? 1 : 3;              if (t > best) begin best = t; bc = 3; end end
            if (sw)   begin t = mainok ? 1 : 3;              if (t > best) begin best = t; bc = 2; end end
            if (best == 3)      begin mk = 2; mcnt = 0; mcause = bc; end
            else if (best == 2) begin mk = 4; mcause = bc; end
            else if (best == 1) begin mk = 3; mcnt = 0; mcause = bc; end
            else begin
                case (mk)
                    1: if (no_por) mk = low ? 4 : 0; else begin mk = 2; mcnt = 0; end
                    2: if (mcnt == STAB_LEN - 1) mk = low ? 4 : 0; else mcnt++;
                    3: if (mcnt == SHORT_LEN - 1) mk = low ? 4 : 0; else mcnt++;
                    4: if (!low) mk = 0;
                    default: mk = 0;
                endcase
            end
            mprev = ms2; ms2 = ms1; ms1 = ext_n;
        end
    end

    always @(negedge clk) begin
        if (!done && $time > 0) begin
            bit e_rst, e_pin, e_force;
            e_rst = (mk != 0);
            e_force = (mk != 0);
            e_pin = !(pin_en && (mk == 1 || mk == 2 || mk == 3));
            vectors++;
            if (sys_rst !== e_rst || pin_n !== e_pin || force_main !== e_force || cause !== mcause[1:0]) begin
                fails++;
                $display("FAIL %s model: rst/pin/force/cause actual %b%b%b/%0d expected %b%b%b/%0d at %0t",
                         cur_req, sys_rst, pin_n, force_main, cause, e_rst, e_pin, e_force, mcause, $time);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drv_wait();
        @(posedge clk); #(CLK_P/4);
    endtask

    task automatic measure();
        bit seen = 0;
        meas_n = 0; pin_low_seen = 0; force_bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (sys_rst) begin
                meas_n++; seen = 1;
                if (!pin_n) pin_low_seen = 1;
                if (!force_main) force_bad = 1;
            end else if (seen) break;
        end
    endtask

    task automatic pulse(input bit is_wdt);
        fork
            begin if (is_wdt) wdt = 1; else sw = 1; drv_wait(); wdt = 0; sw = 0; end
            measure();
        join
    endtask

    task automatic ext_low_for(input int h);
        fork
            begin ext_n = 0; repeat (h) drv_wait(); ext_n = 1; end
            measure();
        join
    endtask

    task automatic por_cycle();
        fork
            begin por = 1; repeat (3) drv_wait(); por = 0; end
            measure();
        join
    endtask

    task automatic idle();
        repeat (4) drv_wait();
    endtask

    initial begin
        #1 por = 1;
        drv_wait();
        cur_req = "R1";
        chk("R1 reset active", sys_rst, 1);
        chk("R1 cause power-on", cause, 0);
        chk("R8 pin low in power-on", pin_n, 0);
        fork
            begin por = 0; end
            measure();
        join
        chk("R1 power-on release length", meas_n, STAB_LEN + 1);
        chk("R9 force main during power-on", force_bad, 0);
        idle();

        cur_req = "R3"; op = 2'd0;
        pulse(0);
        chk("R3 software short pulse", meas_n, SHORT_LEN);
        chk("R10 cause software", cause, 2);
        chk("R8 pin low in short pulse", pin_low_seen, 1);
        idle();
        pulse(1);
        chk("R3 watchdog short pulse", meas_n, SHORT_LEN);
        chk("R10 cause watchdog", cause, 3);
        idle();

        cur_req = "R4"; op = 2'd1;
        pulse(1);
        chk("R4 watchdog in subclock", meas_n, STAB_LEN);
        idle();
        op = 2'd2; pulse(0);
        chk("R4 software in stop", meas_n, STAB_LEN);
        idle();
        op = 2'd3; pulse(0);
        chk("R4 software while settling", meas_n, STAB_LEN);
        chk("R9 force main during settling", force_bad, 0);
        op = 2'd0; idle();

        cur_req = "R13";
        ext_n = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R13 no reset two edges after pin fall", sys_rst, 0);
        @(negedge clk);
        chk("R13 reset at third edge", sys_rst, 1);
        drv_wait(); ext_n = 1;
        repeat (8) drv_wait();

        cur_req = "R5";
        ext_low_for(10);
        chk("R5 pin hold in main", meas_n, 10);
        chk("R10 cause pin", cause, 1);
        chk("R8 pin not driven in pin hold", pin_low_seen, 0);
        idle();

        cur_req = "R6"; op = 2'd2;
        ext_low_for(5);
        chk("R6 pin in stop waits settling", meas_n, STAB_LEN);
        idle();
        cur_req = "R7"; op = 2'd1;
        ext_low_for(50);
        chk("R7 hold extends past settling while pin low", meas_n, 50);
        idle();

        cur_req = "R2"; no_por = 1;
        ext_low_for(5);
        chk("R2 pin in subclock no settling with option", meas_n, 5);
        idle();
        por_cycle();
        chk("R2 power-on release with option", meas_n, 4);
        idle();
        no_por = 0;
        por_cycle();
        chk("R1 power-on release without option", meas_n, 4 + STAB_LEN);
        idle();

        cur_req = "R11"; op = 2'd0;
        fork
            begin sw = 1; wdt = 1; drv_wait(); sw = 0; wdt = 0; end
            measure();
        join
        chk("R11 watchdog beats software", cause, 3);
        idle();
        fork
            begin ext_n = 0; drv_wait(); drv_wait(); sw = 1; drv_wait(); sw = 0;
                  repeat (3) drv_wait(); ext_n = 1; end
            measure();
        join
        chk("R11 pin hold beats short pulse length", meas_n, 6);
        chk("R11 pin hold beats short pulse cause", cause, 1);
        repeat (6) drv_wait();
        no_por = 1; op = 2'd1;
        fork
            begin ext_n = 0; drv_wait(); drv_wait(); wdt = 1; drv_wait(); wdt = 0;
                  drv_wait(); ext_n = 1; end
            measure();
        join
        chk("R11 settling beats pin hold length", meas_n, STAB_LEN);
        chk("R11 settling beats pin hold cause", cause, 3);
        no_por = 0; op = 2'd0;
        idle();

        cur_req = "R12";
        fork
            begin op = 2'd1; wdt = 1; drv_wait(); wdt = 0; op = 2'd0;
                  repeat (9) drv_wait(); sw = 1; drv_wait(); sw = 0; end
            measure();
        join
        chk("R12 restart of settling wait", meas_n, 10 + STAB_LEN);
        chk("R12 restart cause", cause, 2);
        idle();
        fork
            begin sw = 1; drv_wait(); sw = 0; repeat (4) drv_wait(); wdt = 1; drv_wait(); wdt = 0; end
            measure();
        join
        chk("R12 restart of short pulse", meas_n, 5 + SHORT_LEN);
        idle();

        cur_req = "R8"; pin_en = 0;
        pulse(0);
        chk("R8 pin quiet when disabled", pin_low_seen, 0);
        chk("R9 force main in short pulse", force_bad, 0);
        pin_en = 1; idle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            vectors++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule